// File: doc/BRIEF.md
# Fault Escalation Resolver

This block sits beside a processor core's exception logic. When the core reports one or more fault events in a cycle, the block decides which exception is signalled. The event can be a bus error on an instruction fetch, a data access, a vector table read or an exception stack push. It can also be an undefined instruction, an execute-never violation, a protection violation or a security violation. The block picks one of three outcomes: the matching configurable fault handler, the fixed-priority HardFault, or a sticky lockup condition when a HardFault handler is itself faulting.

The decision uses four software enable bits held inside the block, one programmed priority per configurable fault class, the current execution priority, and the number of the exception that is currently active. A configurable fault is redirected to HardFault, with an escalated flag, when its class is disabled, when it cannot outrank the running priority, or when its own handler is the one running. There are two fixed exceptions to this. A vector table read error always goes to HardFault. A stack push error on entry to the bus fault handler always enters the bus fault handler. The fault events are plain level pins sampled every cycle: they form a control interface, not a data stream, so there is no valid/ready handshake and no back-pressure. The core holds an event for exactly the cycle in which it wants a decision.

Top module: `fault_route_unit`

## Requirements
- R1: After reset all four class enables are clear, and `take_exc`, `exc_num`, `escalated` and `lockup` are 0. A cycle with `cfg_wr` high loads `cfg_en` into the enables, with bit 0 for memory management, bit 1 for bus, bit 2 for usage and bit 3 for secure.
- R2: Exception numbers are fixed. HardFault is 3, memory management is 4, bus is 5, usage is 6 and secure is 7. Execute-never and protection violations belong to memory management. Fetch, data and stacking bus errors belong to bus. An undefined instruction belongs to usage. A security violation belongs to secure.
- R3: A fault whose class enable is clear is signalled as exception 3 with `escalated` = 1.
- R4: A fault whose class priority is numerically greater than or equal to `cur_prio` is signalled as exception 3 with `escalated` = 1. A smaller value is more urgent.
- R5: A fault whose own exception number equals `active_exc` is signalled as exception 3 with `escalated` = 1.
- R6: A fault that is enabled, has a priority below `cur_prio` and is not already active is signalled with its own number and `escalated` = 0.
- R7: A vector table read error is signalled as exception 3 with `escalated` = 0, whatever the bus enable and priority are.
- R8: A stacking bus error while `stack_to_bus` is high is signalled as exception 5 with `escalated` = 0, even when bus faults are disabled or outranked.
- R9: When several events arrive in one cycle, the one chosen is the first present in this order: vector read error, secure, memory management, bus, usage. That class alone then goes through R3 to R8.
- R10: Any fault while `active_exc` is 3 sets `lockup` and gives no `take_exc`. Once `lockup` is set it stays set until reset, and no further `take_exc` is produced.
- R11: `take_exc` is high for one cycle, in the cycle after the cycle that held the event. `exc_num` and `escalated` are registered with it and hold their value until the next decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Load the class enables |
| cfg_en | input | 4 | New enables: [0] memory management, [1] bus, [2] usage, [3] secure |
| prio_mem | input | 8 | Memory management fault priority |
| prio_bus | input | 8 | Bus fault priority |
| prio_use | input | 8 | Usage fault priority |
| prio_sec | input | 8 | Secure fault priority |
| cur_prio | input | 8 | Current execution priority |
| active_exc | input | 9 | Number of the active exception |
| ev_vec_err | input | 1 | Bus error on vector table read |
| ev_sec_viol | input | 1 | Security violation |
| ev_xn | input | 1 | Execute from an execute-never region |
| ev_mpu_viol | input | 1 | Protection violation |
| ev_bus_fetch | input | 1 | Bus error on instruction fetch |
| ev_bus_data | input | 1 | Bus error on data access |
| ev_stack_err | input | 1 | Bus error during exception stack push |
| stack_to_bus | input | 1 | The stack push is entering the bus fault handler |
| ev_undef | input | 1 | Undefined instruction |
| take_exc | output | 1 | One-cycle decision strobe |
| exc_num | output | 9 | Chosen exception number |
| escalated | output | 1 | The fault was redirected to HardFault |
| lockup | output | 1 | Sticky lockup indication |

## Verification
Rank selection and escalation of the winner can both happen in one cycle. The bench raises a more urgent event together with a less urgent one, with the more urgent class disabled or outranked. The expected result is a HardFault with `escalated` set, not the less urgent class's own handler. The stacking carve-out is tested in the same way: it is driven alongside a disabled bus class, and the bench expects exception 5 without the flag.

// File: rtl/fru_pkg.sv
`timescale 1ns/1ps
package fru_pkg;
  localparam int EXC_W    = 9;
  localparam int N_RANK   = 5;   // vec, sec, mem, bus, use
  localparam int HARD_NUM = 3;
  localparam int MEM_NUM  = 4;
  localparam int BUS_NUM  = 5;
  localparam int USE_NUM  = 6;
  localparam int SEC_NUM  = 7;
  // enable / priority slot of each configurable class
  localparam int SLOT_MEM = 0;
  localparam int SLOT_BUS = 1;
  localparam int SLOT_USE = 2;
  localparam int SLOT_SEC = 3;
  // rank positions in the request vector
  localparam int RK_VEC = 0;
  localparam int RK_SEC = 1;
  localparam int RK_MEM = 2;
  localparam int RK_BUS = 3;
  localparam int RK_USE = 4;
endpackage

// File: rtl/fru_rank.sv
`timescale 1ns/1ps
module fru_rank #(
  parameter int N = 5
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant[i]  = req[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req[i];
  end
endmodule

// File: rtl/fru_judge.sv
`timescale 1ns/1ps
module fru_judge
  import fru_pkg::*;
#(
  parameter int PRIO_W = 8
) (
  input  logic [N_RANK-1:0]      grant,
  input  logic [3:0]             en,
  input  logic [3:0][PRIO_W-1:0] prio,
  input  logic [PRIO_W-1:0]      cur_prio,
  input  logic [EXC_W-1:0]       active_exc,
  input  logic                   bus_keep,
  output logic                   dec_take,
  output logic                   dec_lock,
  output logic [EXC_W-1:0]       dec_num,
  output logic                   dec_esc
);
  logic             any;
  logic             hard_busy;
  logic [1:0]       slot;
  logic [EXC_W-1:0] own;
  logic             blocked;

  assign any       = |grant;
  assign hard_busy = (active_exc == EXC_W'(HARD_NUM));
  assign dec_lock  = any & hard_busy;
  assign dec_take  = any & ~hard_busy;

  always_comb begin
    slot = 2'(SLOT_USE);
    own  = EXC_W'(USE_NUM);
    if (grant[RK_SEC]) begin
      slot = 2'(SLOT_SEC); own = EXC_W'(SEC_NUM);
    end else if (grant[RK_MEM]) begin
      slot = 2'(SLOT_MEM); own = EXC_W'(MEM_NUM);
    end else if (grant[RK_BUS]) begin
      slot = 2'(SLOT_BUS); own = EXC_W'(BUS_NUM);
    end
  end

  assign blocked = ~en[slot] | (prio[slot] >= cur_prio) | (active_exc == own);

  always_comb begin
    dec_num = '0;
    dec_esc = 1'b0;
    if (grant[RK_VEC]) begin
      dec_num = EXC_W'(HARD_NUM);
    end else if (grant[RK_BUS] && bus_keep) begin
      dec_num = EXC_W'(BUS_NUM);
    end else if (any) begin
      dec_num = blocked ? EXC_W'(HARD_NUM) : own;
      dec_esc = blocked;
    end
  end
endmodule

// File: rtl/fault_route_unit.sv
`timescale 1ns/1ps
module fault_route_unit
  import fru_pkg::*;
#(
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [3:0]        cfg_en,
  input  logic [PRIO_W-1:0] prio_mem,
  input  logic [PRIO_W-1:0] prio_bus,
  input  logic [PRIO_W-1:0] prio_use,
  input  logic [PRIO_W-1:0] prio_sec,
  input  logic [PRIO_W-1:0] cur_prio,
  input  logic [EXC_W-1:0]  active_exc,
  input  logic              ev_vec_err,
  input  logic              ev_sec_viol,
  input  logic              ev_xn,
  input  logic              ev_mpu_viol,
  input  logic              ev_bus_fetch,
  input  logic              ev_bus_data,
  input  logic              ev_stack_err,
  input  logic              stack_to_bus,
  input  logic              ev_undef,
  output logic              take_exc,
  output logic [EXC_W-1:0]  exc_num,
  output logic              escalated,
  output logic              lockup
);
  logic [3:0]             en_q;
  logic [N_RANK-1:0]      req, grant;
  logic [3:0][PRIO_W-1:0] prio;
  logic                   dec_take, dec_lock, dec_esc;
  logic [EXC_W-1:0]       dec_num;

  assign req[RK_VEC] = ev_vec_err  & ~lockup;
  assign req[RK_SEC] = ev_sec_viol & ~lockup;
  assign req[RK_MEM] = (ev_xn | ev_mpu_viol) & ~lockup;
  assign req[RK_BUS] = (ev_bus_fetch | ev_bus_data | ev_stack_err) & ~lockup;
  assign req[RK_USE] = ev_undef & ~lockup;

  assign prio[SLOT_MEM] = prio_mem;
  assign prio[SLOT_BUS] = prio_bus;
  assign prio[SLOT_USE] = prio_use;
  assign prio[SLOT_SEC] = prio_sec;

  fru_rank #(.N(N_RANK)) u_rank (.req(req), .grant(grant));

  fru_judge #(.PRIO_W(PRIO_W)) u_judge (
    .grant(grant), .en(en_q), .prio(prio), .cur_prio(cur_prio),
    .active_exc(active_exc), .bus_keep(ev_stack_err & stack_to_bus),
    .dec_take(dec_take), .dec_lock(dec_lock),
    .dec_num(dec_num), .dec_esc(dec_esc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= '0;
      take_exc  <= 1'b0;
      exc_num   <= '0;
      escalated <= 1'b0;
      lockup    <= 1'b0;
    end else begin
      if (cfg_wr) en_q <= cfg_en;
      take_exc <= dec_take;
      if (dec_take) begin
        exc_num   <= dec_num;
        escalated <= dec_esc;
      end
      if (dec_lock) lockup <= 1'b1;
    end
  end
endmodule

// File: rtl/fru_checker.sv
`timescale 1ns/1ps
module fru_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [8:0] active_exc,
  input logic       ev_vec_err,
  input logic       ev_sec_viol,
  input logic       ev_xn,
  input logic       ev_mpu_viol,
  input logic       ev_bus_fetch,
  input logic       ev_bus_data,
  input logic       ev_stack_err,
  input logic       stack_to_bus,
  input logic       ev_undef,
  input logic       take_exc,
  input logic [8:0] exc_num,
  input logic       escalated,
  input logic       lockup
);
  logic any_ev;
  assign any_ev = ev_vec_err | ev_sec_viol | ev_xn | ev_mpu_viol |
                  ev_bus_fetch | ev_bus_data | ev_stack_err | ev_undef;

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    lockup |=> lockup);                                           // R10
  AST_LOCK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    lockup |=> !take_exc);                                        // R10
  AST_HARD_IN_HARD: assert property (@(posedge clk) disable iff (!rst_n)
    (any_ev && active_exc == 9'd3) |=> lockup && !take_exc);      // R10
  AST_ESC_IS_HARD: assert property (@(posedge clk) disable iff (!rst_n)
    (take_exc && escalated) |-> exc_num == 9'd3);                 // R3
  AST_VEC_HARD: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_vec_err && !lockup && active_exc != 9'd3)
      |=> take_exc && exc_num == 9'd3 && !escalated);             // R7
  AST_STACK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stack_err && stack_to_bus && !ev_vec_err && !ev_sec_viol &&
     !ev_xn && !ev_mpu_viol && !lockup && active_exc != 9'd3)
      |=> take_exc && exc_num == 9'd5 && !escalated);             // R8
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !take_exc |-> $stable(exc_num) && $stable(escalated));        // R11
endmodule

bind fault_route_unit fru_checker u_chk (
  .clk(clk), .rst_n(rst_n), .active_exc(active_exc),
  .ev_vec_err(ev_vec_err), .ev_sec_viol(ev_sec_viol), .ev_xn(ev_xn),
  .ev_mpu_viol(ev_mpu_viol), .ev_bus_fetch(ev_bus_fetch),
  .ev_bus_data(ev_bus_data), .ev_stack_err(ev_stack_err),
  .stack_to_bus(stack_to_bus), .ev_undef(ev_undef),
  .take_exc(take_exc), .exc_num(exc_num), .escalated(escalated),
  .lockup(lockup)
);

// File: tb/sim_fault_route_unit.sv
`timescale 1ns/1ps
module sim_fault_route_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [3:0] cfg_en = '0;
  logic [7:0] prio_mem = 8'h40, prio_bus = 8'h40, prio_use = 8'h40, prio_sec = 8'h40;
  logic [7:0] cur_prio = 8'h80;
  logic [8:0] active_exc = '0;
  logic ev_vec_err = 0, ev_sec_viol = 0, ev_xn = 0, ev_mpu_viol = 0;
  logic ev_bus_fetch = 0, ev_bus_data = 0, ev_stack_err = 0, stack_to_bus = 0, ev_undef = 0;
  logic       take_exc, escalated, lockup;
  logic [8:0] exc_num;

  always #2.5 clk = ~clk;

  fault_route_unit u0 (.*);

  typedef struct packed {
    logic       take;
    logic [8:0] num;
    logic       esc;
    logic       lock;
    logic [3:0] rq;
  } exp_t;

  exp_t q[$];
  int   checks = 0, errors = 0;
  logic done = 1'b0;

  logic [3:0] m_en = '0;
  logic [8:0] m_num = '0;
  logic       m_esc = 1'b0, m_lock = 1'b0;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", rq, act, exp);
    end
  endtask

  // Outcome for one class, from the requirements.
  function automatic void judge(input logic en, input logic [7:0] pr, input logic [8:0] own,
                                output logic [8:0] n, output logic e);
    if (!en || pr >= cur_prio || active_exc == own) begin n = 9'd3; e = 1'b1; end
    else begin n = own; e = 1'b0; end
  endfunction

  task automatic drive(input int rq, input logic vec, input logic sec, input logic xn,
                       input logic mpu, input logic bf, input logic bd, input logic se,
                       input logic stb, input logic ud);
    exp_t x;
    logic [8:0] n;
    logic e;
    logic anyv;
    @(negedge clk);
    {ev_vec_err, ev_sec_viol, ev_xn, ev_mpu_viol} = {vec, sec, xn, mpu};
    {ev_bus_fetch, ev_bus_data, ev_stack_err, stack_to_bus, ev_undef} = {bf, bd, se, stb, ud};
    anyv = vec | sec | xn | mpu | bf | bd | se | ud;
    n = m_num; e = m_esc;
    x.take = 1'b0;
    if (!m_lock && anyv) begin
      if (active_exc == 9'd3) m_lock = 1'b1;
      else begin
        x.take = 1'b1;
        if (vec) begin n = 9'd3; e = 1'b0; end
        else if (sec) judge(m_en[3], prio_sec, 9'd7, n, e);
        else if (xn | mpu) judge(m_en[0], prio_mem, 9'd4, n, e);
        else if (bf | bd | se) begin
          if (se && stb) begin n = 9'd5; e = 1'b0; end
          else judge(m_en[1], prio_bus, 9'd5, n, e);
        end
        else judge(m_en[2], prio_use, 9'd6, n, e);
      end
    end
    m_num = n; m_esc = e;
    x.num = n; x.esc = e; x.lock = m_lock; x.rq = 4'(rq);
    q.push_back(x);
    @(negedge clk);
    {ev_vec_err, ev_sec_viol, ev_xn, ev_mpu_viol} = '0;
    {ev_bus_fetch, ev_bus_data, ev_stack_err, stack_to_bus, ev_undef} = '0;
  endtask

  task automatic set_en(input logic [3:0] v);
    @(negedge clk); cfg_wr = 1'b1; cfg_en = v;
    @(negedge clk); cfg_wr = 1'b0; m_en = v;
  endtask

  // Monitor: pops one expected item per decision cycle.
  initial begin
    forever begin
      @(posedge clk);
      if (q.size() != 0) begin
        exp_t x;
        string tag;
        #1;
        x = q.pop_front();
        tag = $sformatf("R%0d", x.rq);
        chk(tag, {31'd0, take_exc}, {31'd0, x.take});
        chk(tag, {23'd0, exc_num}, {23'd0, x.num});
        chk(tag, {31'd0, escalated}, {31'd0, x.esc});
        chk(tag, {31'd0, lockup}, {31'd0, x.lock});
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", {28'd0, take_exc, escalated, lockup, |exc_num}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R3 and R1: enables start clear, so usage escalates
    drive(3, 0,0,0,0,0,0,0,0,1);
    set_en(4'b1111);                       // R1 load
    drive(6, 0,0,0,0,0,0,0,0,1);           // R6 usage taken
    drive(2, 0,0,0,1,0,0,0,0,0);           // R2 protection -> 4
    drive(2, 0,1,0,0,0,0,0,0,0);           // R2 secure -> 7
    drive(2, 0,0,0,0,0,1,0,0,0);           // R2 data bus -> 5
    prio_use = 8'h80;
    drive(4, 0,0,0,0,0,0,0,0,1);           // R4 equal priority
    prio_use = 8'h90;
    drive(4, 0,0,0,0,0,0,0,0,1);           // R4 lower urgency
    prio_use = 8'h40;
    active_exc = 9'd4;
    drive(5, 0,0,1,0,0,0,0,0,0);           // R5 xn inside own handler
    active_exc = 9'd0;
    set_en(4'b1101);                       // bus off
    drive(7, 1,0,0,0,0,0,0,0,0);           // R7 vector read
    drive(8, 0,0,0,0,0,0,1,1,0);           // R8 stacking into bus handler
    drive(3, 0,0,0,0,0,0,1,0,0);           // R3 plain stacking error, bus off
    drive(9, 0,1,0,0,0,0,0,0,1);           // R9 secure wins over usage
    set_en(4'b1110);                       // memory management off
    drive(9, 0,0,1,0,1,0,0,0,1);           // R9 mem wins, then escalates
    drive(9, 1,1,0,0,0,0,0,0,0);           // R9 vector read wins
    // R11: result holds on an idle cycle
    @(negedge clk); @(negedge clk);
    chk("R11", {22'd0, take_exc, exc_num}, {22'd0, 1'b0, m_num});
    active_exc = 9'd3;
    drive(10, 0,0,0,0,0,0,0,0,1);          // R10 lockup
    active_exc = 9'd0;
    drive(10, 0,1,0,0,0,0,0,0,0);          // R10 no take while locked
    @(negedge clk); @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10", {31'd0, lockup}, 32'd0);
    rst_n = 1'b1; m_lock = 1'b0; m_en = '0; m_num = '0; m_esc = 1'b0;
    drive(1, 0,1,0,0,0,0,0,0,0);           // R1 enables cleared again
    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule